// File: doc/BRIEF.md
# DMA Completion Interrupt Control Register

This block is the interrupt-control word of a seven-channel DMA controller. It holds six general-purpose read-write bits, a force bit, one interrupt-enable bit per channel, a master enable, and one sticky completion flag per channel. The word also carries a read-only summary flag. The summary flag is recomputed every cycle from the other fields.

Software writes the whole 32-bit word in one cycle. The bits in the lower half and in the enable byte are loaded directly from the written data. A 1 written to a flag bit clears that flag, and a 0 leaves it alone. Each channel engine gives a one-cycle completion pulse, which sets the channel's flag when that channel's enable bit is set.

The block sends an interrupt request to the system interrupt controller as a one-cycle pulse. The pulse marks the cycle in which the summary flag turns from 0 to 1.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is cleared to 0x00000000 and `irq_pulse` is low in the following cycle.
- R2: A write (`wr_en` high) loads bits 5:0 and bits 23:15 from `wr_data` at the clock edge. Bits 14:6 always read as 0.
- R3: For each channel c, a write with `wr_data[24+c]` = 1 clears flag bit 24+c. A write with that data bit at 0 leaves the flag unchanged.
- R4: A completion pulse `done_i[c]` sets flag bit 24+c at the clock edge when enable bit 16+c is set. When enable bit 16+c is clear, the pulse has no effect.
- R5: Bit 31 reads as bit15 OR (bit23 AND any of (bits 22:16 AND bits 30:24)). The value written to bit 31 has no effect.
- R6: `irq_pulse` is high for exactly the one cycle in which bit 31 reads 1 after having read 0 in the previous cycle. It stays low while bit 31 stays high.
- R7: If a completion pulse and a write-1-to-clear hit the same enabled flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| done_i | input | 7 | Per-channel completion pulses |
| rd_data | output | 32 | Current register value including the summary flag |
| irq_pulse | output | 1 | Interrupt request, one cycle on the summary-flag rising edge |

## Verification
The bench aims at four corner cases, and each one shows a specific design fault:
- **Clear and set in the same cycle.** A design that lets the clear win would lose a completion, so no interrupt would be raised on that cycle.
- **Writing bit 31 and the unused middle bits.** A design that stores the written data would report a summary flag with no cause, or show bits that should read 0.
- **Completion on a disabled channel.** A design that ignores the enable would set a flag on such a pulse.
- **Summary flag staying high.** The bench holds the flag high across several cycles and later makes it rise a second time. A level-driven request would repeat while the flag stays high, and a latched request would miss the second rising edge.

// File: rtl/dma_irq_pkg.sv
// Package: shared field positions of the DMA interrupt-control word.
// Assumes a 32-bit word. The channel count fixes where the enable byte,
// the master enable, the flag byte and the summary bit sit.
package dma_irq_pkg;
    localparam int WORD_W    = 32;
    localparam int CH_COUNT  = 7;
    localparam int SPARE_W   = 6;
    localparam int FORCE_POS = 15;
    localparam int EN_LO     = FORCE_POS + 1;
    localparam int MEN_POS   = EN_LO + CH_COUNT;
    localparam int FLAG_LO   = MEN_POS + 1;
    localparam int SUM_POS   = FLAG_LO + CH_COUNT;
    localparam int GAP_W     = FORCE_POS - SPARE_W;
endpackage

// File: rtl/dma_irq_fields.sv
// Module: plain read-write fields of the interrupt-control word.
// Holds the spare bits, force bit, per-channel enables and master enable.
// All of them are loaded from the write data whenever wr_en is high.
// Assumes a synchronous active-low reset.
module dma_irq_fields #(
    parameter int NCH     = 7,
    parameter int SPARE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SPARE_W-1:0] wr_spare,
    input  logic               wr_force,
    input  logic [NCH-1:0]     wr_enable,
    input  logic               wr_master_en,
    output logic [SPARE_W-1:0] spare_q,
    output logic               force_q,
    output logic [NCH-1:0]     enable_q,
    output logic               master_en_q
);
    // Load every read-write field from the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q     <= '0;
            force_q     <= 1'b0;
            enable_q    <= '0;
            master_en_q <= 1'b0;
        end else if (wr_en) begin
            spare_q     <= wr_spare;
            force_q     <= wr_force;
            enable_q    <= wr_enable;
            master_en_q <= wr_master_en;
        end
    end
endmodule

// File: rtl/dma_irq_flags.sv
// Module: sticky per-channel completion flags.
// A flag is set by an enabled completion pulse and cleared by a
// write-1-to-clear request. A set in the same cycle takes precedence
// over a clear. Assumes a synchronous active-low reset.
module dma_irq_flags #(
    parameter int NCH = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done_i,
    input  logic [NCH-1:0] enable_q,
    input  logic [NCH-1:0] clr_req,
    output logic [NCH-1:0] flag_q
);
    for (genvar c = 0; c < NCH; c++) begin : g_flag
        logic set_c;
        assign set_c = done_i[c] & enable_q[c];

        // Update one channel flag: set wins, then clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[c] <= 1'b0;
            end else if (set_c) begin
                flag_q[c] <= 1'b1;
            end else if (clr_req[c]) begin
                flag_q[c] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_irq_summary.sv
// Module: summary-flag computation and interrupt edge detector.
// The summary is derived each cycle from the stored fields. The request
// pulse is high in the first cycle in which the summary reads 1.
// Assumes a synchronous active-low reset that clears the history bit.
module dma_irq_summary #(
    parameter int NCH = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           force_q,
    input  logic           master_en_q,
    input  logic [NCH-1:0] enable_q,
    input  logic [NCH-1:0] flag_q,
    output logic           summary,
    output logic           irq_pulse
);
    logic summary_prev;

    // Combine force and the enabled flags into the summary flag.
    always_comb begin
        summary = force_q | (master_en_q & (|(enable_q & flag_q)));
    end

    // Remember the previous summary value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            summary_prev <= 1'b0;
        end else begin
            summary_prev <= summary;
        end
    end

    assign irq_pulse = summary & ~summary_prev;
endmodule

// File: rtl/dma_irq_ctrl.sv
// Module: top of the DMA interrupt-control register.
// Splits a write into field loads and flag clears, collects the stored
// fields into the readable word and drives the interrupt request pulse.
// Assumes single-cycle writes and single-cycle completion pulses.
module dma_irq_ctrl
    import dma_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [CH_COUNT-1:0] done_i,
    output logic [WORD_W-1:0]   rd_data,
    output logic                irq_pulse
);
    logic [SPARE_W-1:0]  spare_q;
    logic                force_q;
    logic [CH_COUNT-1:0] enable_q;
    logic                master_en_q;
    logic [CH_COUNT-1:0] flag_q;
    logic [CH_COUNT-1:0] clr_req;
    logic                summary;

    // Clear requests exist only in a write cycle.
    always_comb begin
        clr_req = wr_en ? wr_data[FLAG_LO +: CH_COUNT] : '0;
    end

    dma_irq_fields #(.NCH(CH_COUNT), .SPARE_W(SPARE_W)) u_fields (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_spare     (wr_data[SPARE_W-1:0]),
        .wr_force     (wr_data[FORCE_POS]),
        .wr_enable    (wr_data[EN_LO +: CH_COUNT]),
        .wr_master_en (wr_data[MEN_POS]),
        .spare_q      (spare_q),
        .force_q      (force_q),
        .enable_q     (enable_q),
        .master_en_q  (master_en_q)
    );

    dma_irq_flags #(.NCH(CH_COUNT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done_i),
        .enable_q (enable_q),
        .clr_req  (clr_req),
        .flag_q   (flag_q)
    );

    dma_irq_summary #(.NCH(CH_COUNT)) u_summary (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_q     (force_q),
        .master_en_q (master_en_q),
        .enable_q    (enable_q),
        .flag_q      (flag_q),
        .summary     (summary),
        .irq_pulse   (irq_pulse)
    );

    // Place every field at its position in the readable word.
    always_comb begin
        rd_data = {summary, flag_q, master_en_q, enable_q, force_q,
                   {GAP_W{1'b0}}, spare_q};
    end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
// Module: assertion checker for dma_irq_ctrl, attached to it through bind.
// Observes only the ports of the top module.
module dma_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [6:0]  done_i,
    input logic [31:0] rd_data,
    input logic        irq_pulse
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 32'h0) && !irq_pulse); // R1

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[23:15] == $past(wr_data[23:15])) &&
                  (rd_data[5:0] == $past(wr_data[5:0]))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data[30:24] & $past(wr_data[30:24] & ~done_i)) == 7'h0)); // R3

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_i & rd_data[22:16])) |=>
            ((rd_data[30:24] & $past(done_i & rd_data[22:16])) ==
             $past(done_i & rd_data[22:16]))); // R4

    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[31]) |-> irq_pulse); // R6

    AST_PULSE_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> rd_data[31] && !$past(rd_data[31])); // R6
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .done_i    (done_i),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
);

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  done_i = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    dma_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .done_i    (done_i),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    // Vector fields: {wr_en, wr_data, done, expected rd_data, expected pulse}
    localparam int NV = 17;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 32'h0000_003F, 7'h00, 32'h0000_003F, 1'b0}, // R2 spare bits
        {1'b1, 32'h0000_7FC0, 7'h00, 32'h0000_0000, 1'b0}, // R2 gap reads zero
        {1'b1, 32'h007F_0000, 7'h00, 32'h007F_0000, 1'b0}, // R2 enables
        {1'b0, 32'h0000_0000, 7'h05, 32'h057F_0000, 1'b0}, // R4 flags set
        {1'b1, 32'h00FF_0000, 7'h00, 32'h85FF_0000, 1'b1}, // R5 master on
        {1'b0, 32'h0000_0000, 7'h00, 32'h85FF_0000, 1'b0}, // R6 no repeat
        {1'b1, 32'h01FF_0000, 7'h00, 32'h84FF_0000, 1'b0}, // R3 clear one
        {1'b1, 32'h04FF_0000, 7'h00, 32'h00FF_0000, 1'b0}, // R3 clear last
        {1'b1, 32'h00FF_8000, 7'h00, 32'h80FF_8000, 1'b1}, // R5 force
        {1'b1, 32'h0000_0000, 7'h00, 32'h0000_0000, 1'b0}, // R2 clear all
        {1'b1, 32'h8000_0000, 7'h00, 32'h0000_0000, 1'b0}, // R5 bit31 ignored
        {1'b1, 32'h0001_0000, 7'h02, 32'h0001_0000, 1'b0}, // R4 disabled done
        {1'b0, 32'h0000_0000, 7'h01, 32'h0101_0000, 1'b0}, // R4 enabled done
        {1'b1, 32'h0181_0000, 7'h01, 32'h8181_0000, 1'b1}, // R7 set wins
        {1'b1, 32'h0181_0000, 7'h00, 32'h0081_0000, 1'b0}, // R3 clear
        {1'b0, 32'h0000_0000, 7'h01, 32'h8181_0000, 1'b1}, // R6 second rise
        {1'b0, 32'h0000_0000, 7'h01, 32'h8181_0000, 1'b0}  // R6 held high
    };
    localparam logic [15:0] TAG [NV] = '{
        "R2", "R2", "R2", "R4", "R5", "R6", "R3", "R3", "R5",
        "R2", "R5", "R4", "R4", "R7", "R3", "R6", "R6"
    };

    task automatic check32(input logic [15:0] req, input logic [31:0] act,
                           input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s rd_data actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic check1(input logic [15:0] req, input logic act,
                          input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s irq_pulse actual %0b expected %0b", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check32("R1", rd_data, 32'h0);
        check1("R1", irq_pulse, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en   = VEC[i][72];
            wr_data = VEC[i][71:40];
            done_i  = VEC[i][39:33];
            @(posedge clk);
            #1;
            check32(TAG[i], rd_data, VEC[i][32:1]);
            check1(TAG[i], irq_pulse, VEC[i][0]);
        end
        // R1: reset taken mid-state, with a write pending, still clears all
        @(negedge clk);
        rst_n   = 1'b0;
        wr_en   = 1'b1;
        wr_data = 32'h00FF_803F;
        done_i  = 7'h7F;
        @(posedge clk);
        #1;
        check32("R1", rd_data, 32'h0);
        check1("R1", irq_pulse, 1'b0);
        // R6: after reset, force raises a fresh pulse
        @(negedge clk);
        rst_n   = 1'b1;
        done_i  = 7'h00;
        wr_data = 32'h0000_8000;
        @(posedge clk);
        #1;
        check32("R6", rd_data, 32'h8000_8000);
        check1("R6", irq_pulse, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule